// File: doc/BRIEF.md
# Frame Descriptor Walker

This block runs the per-frame descriptor fetch for a set of display DMA channels. A pulse on `frame_start` starts a walk. The walk first zeroes every channel's source address. It then visits the channels in ascending index order and passes over any channel whose `chan_active` bit is low.

For each active channel the walker picks a descriptor address. An armed branch register supplies it once; otherwise the channel's stored next-descriptor pointer is used. The walker checks that address against a permitted memory window. It then reads a 16-byte descriptor as four word reads over a valid/ready request channel with a separate response strobe. The descriptor words are, in order: next pointer, frame source address, frame tag, and command.

After the fetch, the walker validates the source address and reports what it found as single-cycle event pulses tagged with the channel number. The possible outcomes are a bus error, a palette load, or a pixel frame. For a pixel frame the walker waits for an external transfer-complete strobe before it signals end of frame. A small write port loads the per-channel pointer and branch registers, and a read-only peek port exposes each channel's state.

Top module: `frame_desc_walker`

## Requirements
- R1: A descriptor at address A is read as four requests at A, A+4, A+8 and A+12, each held with valid until ready and each waiting for its response. The words are stored, in that order, as the channel's next pointer, source address, frame tag and command.
- R2: A `frame_start` pulse while idle starts a walk. The walk visits channels 0 upward, skips inactive channels without reading memory, and ends with one `walk_done` pulse. A `frame_start` pulse during a walk is ignored.
- R3: At the start of every walk, the source address of every channel, active or not, is set to zero.
- R4: When branch bit 0 (armed) is set, the descriptor address is branch bits 31:4 with the low four bits zero, and bit 0 is cleared. If bit 1 is also set, `evt_branch` pulses for the channel; if bit 1 is clear, there is no pulse. When bit 0 is clear, the stored next pointer is used.
- R5: A descriptor is fetched only if A >= WIN_BASE and A+16 <= WIN_BASE+WIN_SIZE. Otherwise no read is issued and the channel's source address stays zero.
- R6: After the fetch step, a source address that is zero, below WIN_BASE or above WIN_BASE+WIN_SIZE (the upper bound is included) gives `evt_bus_err` for that channel. That channel then produces no other event.
- R7: A command with bit 26 set is a palette load. It gives `evt_palette`, with `evt_len` equal to command bits 20:2 times four, and no start or end of frame.
- R8: Any other valid command gives `evt_sof`, with `evt_len` equal to command bits 20:2 times four. The walker then waits for `xfer_done` before it pulses `evt_eof` and moves to the next channel.
- R9: A write with `cfg_wr_sel`=0 sets the channel's next pointer with its low four bits forced to zero. A write with `cfg_wr_sel`=1 sets the branch register ANDed with 0xFFFFFFF3.
- R10: Event pulses last one cycle, at most one is high in any cycle, and `evt_ch` carries the channel number.
- R11: After reset the walker is idle, issues no request, and every channel register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Begin a walk |
| chan_active | input | NCH | Per-channel enable for this walk |
| xfer_done | input | 1 | Pixel transfer of the current channel finished |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0: next pointer, 1: branch register |
| cfg_wr_ch | input | CHW | Channel written |
| cfg_wr_data | input | 32 | Write data |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 32 | Read data |
| evt_branch | output | 1 | Branch-interrupt event |
| evt_sof | output | 1 | Start of pixel frame |
| evt_eof | output | 1 | End of pixel frame |
| evt_palette | output | 1 | Palette load |
| evt_bus_err | output | 1 | Bus error |
| evt_ch | output | CHW | Channel of the event |
| evt_len | output | 21 | Transfer length in bytes |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | Walk finished |
| peek_ch | input | CHW | Channel shown on the peek outputs |
| peek_next | output | 32 | Next descriptor pointer |
| peek_src | output | 32 | Source address |
| peek_id | output | 32 | Frame tag |
| peek_cmd | output | 32 | Command word |
| peek_branch | output | 32 | Branch register |

## Verification
Most internal faults in this walker show up at the ports within the same channel's visit. A wrong channel counter or skip decision changes `evt_ch` or the order of the event stream. A wrong word index or address step makes the request address leave the expected sequence, so the memory model returns data that yields a different event or length. State that survives from one frame to the next, such as branch arming, followed next pointers and source clearing, is only visible one walk later. The bench therefore runs two walks back to back and compares the peek outputs after each.

// File: rtl/fdw_pkg.sv
package fdw_pkg;
    typedef enum logic [2:0] {
        FDW_IDLE,
        FDW_SCAN,
        FDW_REQ,
        FDW_RSP,
        FDW_CHECK,
        FDW_XFER
    } fdw_state_e;

    localparam int          DESC_BYTES = 16;
    localparam int          PAL_BIT    = 26;
    localparam int          BR_ARM     = 0;
    localparam int          BR_INT     = 1;
    localparam logic [31:0] BR_MASK    = 32'hFFFF_FFF3;
    localparam logic [31:0] PTR_MASK   = 32'hFFFF_FFF0;
endpackage

// File: rtl/fdw_window_chk.sv
module fdw_window_chk #(
    parameter logic [31:0] WIN_BASE = 32'h1000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0000_0400
) (
    input  logic [31:0] desc_addr,
    input  logic [31:0] src_addr,
    output logic        desc_ok,
    output logic        src_ok
);
    localparam logic [32:0] LO = {1'b0, WIN_BASE};
    localparam logic [32:0] HI = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

    always_comb begin
        desc_ok = ({1'b0, desc_addr} >= LO) &&
                  (({1'b0, desc_addr} + 33'(fdw_pkg::DESC_BYTES)) <= HI);
        src_ok  = (src_addr != 32'h0) && ({1'b0, src_addr} >= LO) &&
                  ({1'b0, src_addr} <= HI);
    end
endmodule

// File: rtl/fdw_chan_bank.sv
module fdw_chan_bank #(
    parameter int NCH = 7,
    parameter int CHW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_sel,
    input  logic [CHW-1:0]  wr_ch,
    input  logic [31:0]     wr_data,
    input  logic            clr_src,
    input  logic            ld_en,
    input  logic [CHW-1:0]  ld_ch,
    input  logic [31:0]     ld_next,
    input  logic [31:0]     ld_src,
    input  logic [31:0]     ld_id,
    input  logic [31:0]     ld_cmd,
    input  logic            dis_en,
    input  logic [CHW-1:0]  dis_ch,
    input  logic [CHW-1:0]  eng_ch,
    output logic [31:0]     eng_next,
    output logic [31:0]     eng_src,
    output logic            eng_pal,
    output logic [20:0]     eng_len,
    output logic            eng_br_arm,
    output logic            eng_br_int,
    output logic [31:0]     eng_br_addr,
    input  logic [CHW-1:0]  pk_ch,
    output logic [31:0]     pk_next,
    output logic [31:0]     pk_src,
    output logic [31:0]     pk_id,
    output logic [31:0]     pk_cmd,
    output logic [31:0]     pk_br
);
    import fdw_pkg::*;

    typedef struct packed {
        logic [NCH-1:0][31:0] nxt;
        logic [NCH-1:0][31:0] src;
        logic [NCH-1:0][31:0] id;
        logic [NCH-1:0][31:0] cmd;
        logic [NCH-1:0][31:0] br;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (clr_src) begin
            bank_d.src = '0;
        end
        if (ld_en) begin
            bank_d.nxt[ld_ch] = ld_next;
            bank_d.src[ld_ch] = ld_src;
            bank_d.id[ld_ch]  = ld_id;
            bank_d.cmd[ld_ch] = ld_cmd;
        end
        if (dis_en) begin
            bank_d.br[dis_ch][BR_ARM] = 1'b0;
        end
        // a register write in the same cycle wins over the engine
        if (wr_en && (int'(wr_ch) < NCH)) begin
            if (wr_sel) bank_d.br[wr_ch]  = wr_data & BR_MASK;
            else        bank_d.nxt[wr_ch] = wr_data & PTR_MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        eng_next = 32'h0; eng_src = 32'h0; eng_pal = 1'b0; eng_len = 21'h0;
        eng_br_arm = 1'b0; eng_br_int = 1'b0; eng_br_addr = 32'h0;
        if (int'(eng_ch) < NCH) begin
            eng_next    = bank_q.nxt[eng_ch];
            eng_src     = bank_q.src[eng_ch];
            eng_pal     = bank_q.cmd[eng_ch][PAL_BIT];
            eng_len     = {bank_q.cmd[eng_ch][20:2], 2'b00};
            eng_br_arm  = bank_q.br[eng_ch][BR_ARM];
            eng_br_int  = bank_q.br[eng_ch][BR_INT];
            eng_br_addr = {bank_q.br[eng_ch][31:4], 4'h0};
        end
    end

    always_comb begin
        pk_next = 32'h0; pk_src = 32'h0; pk_id = 32'h0; pk_cmd = 32'h0; pk_br = 32'h0;
        if (int'(pk_ch) < NCH) begin
            pk_next = bank_q.nxt[pk_ch];
            pk_src  = bank_q.src[pk_ch];
            pk_id   = bank_q.id[pk_ch];
            pk_cmd  = bank_q.cmd[pk_ch];
            pk_br   = bank_q.br[pk_ch];
        end
    end

    AST_SRC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_src |=> (bank_q.src == '0)); // R3

    AST_BR_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_en && !(wr_en && wr_sel && (wr_ch == dis_ch)))
        |=> !bank_q.br[$past(dis_ch)][BR_ARM]); // R4

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && (int'(wr_ch) < NCH))
        |=> (bank_q.nxt[$past(wr_ch)][3:0] == 4'h0)); // R9
endmodule

// File: rtl/fdw_walker.sv
module fdw_walker #(
    parameter int          NCH      = 7,
    parameter int          CHW      = 3,
    parameter int          CNTW     = 3,
    parameter logic [31:0] WIN_BASE = 32'h1000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0000_0400
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [NCH-1:0]  chan_active,
    input  logic            xfer_done,
    input  logic            desc_ok,
    input  logic            src_ok,
    input  logic [31:0]     eng_next,
    input  logic            eng_pal,
    input  logic [20:0]     eng_len,
    input  logic            eng_br_arm,
    input  logic            eng_br_int,
    input  logic [31:0]     eng_br_addr,
    output logic [CHW-1:0]  eng_ch,
    output logic [31:0]     cand_addr,
    output logic            clr_src,
    output logic            ld_en,
    output logic [CHW-1:0]  ld_ch,
    output logic [31:0]     ld_next,
    output logic [31:0]     ld_src,
    output logic [31:0]     ld_id,
    output logic [31:0]     ld_cmd,
    output logic            dis_en,
    output logic [CHW-1:0]  dis_ch,
    output logic            rd_req_valid,
    input  logic            rd_req_ready,
    output logic [31:0]     rd_req_addr,
    input  logic            rd_rsp_valid,
    input  logic [31:0]     rd_rsp_data,
    output logic            evt_branch,
    output logic            evt_sof,
    output logic            evt_eof,
    output logic            evt_palette,
    output logic            evt_bus_err,
    output logic [CHW-1:0]  evt_ch,
    output logic [20:0]     evt_len,
    output logic            walk_busy,
    output logic            walk_done
);
    import fdw_pkg::*;

    typedef struct packed {
        fdw_state_e       st;
        logic [CNTW-1:0]  ch;
        logic [1:0]       widx;
        logic [31:0]      daddr;
        logic [31:0]      w0;
        logic [31:0]      w1;
        logic [31:0]      w2;
        logic             ev_br;
        logic             ev_sof;
        logic             ev_eof;
        logic             ev_pal;
        logic             ev_berr;
        logic [CHW-1:0]   ev_ch;
        logic [20:0]      ev_len;
        logic             done;
    } walk_t;

    walk_t w_d, w_q;

    assign eng_ch      = w_q.ch[CHW-1:0];
    assign ld_ch       = w_q.ch[CHW-1:0];
    assign dis_ch      = w_q.ch[CHW-1:0];
    assign ld_next     = w_q.w0;
    assign ld_src      = w_q.w1;
    assign ld_id       = w_q.w2;
    assign ld_cmd      = rd_rsp_data;
    assign rd_req_addr = w_q.daddr + 32'({w_q.widx, 2'b00});
    assign cand_addr   = eng_br_arm ? eng_br_addr : eng_next;

    always_comb begin
        w_d          = w_q;
        w_d.ev_br    = 1'b0;
        w_d.ev_sof   = 1'b0;
        w_d.ev_eof   = 1'b0;
        w_d.ev_pal   = 1'b0;
        w_d.ev_berr  = 1'b0;
        w_d.done     = 1'b0;
        clr_src      = 1'b0;
        ld_en        = 1'b0;
        dis_en       = 1'b0;
        rd_req_valid = 1'b0;
        unique case (w_q.st)
            FDW_IDLE: begin
                if (frame_start) begin
                    clr_src = 1'b1;
                    w_d.ch  = '0;
                    w_d.st  = FDW_SCAN;
                end
            end
            FDW_SCAN: begin
                if (w_q.ch == CNTW'(NCH)) begin
                    w_d.done = 1'b1;
                    w_d.st   = FDW_IDLE;
                end else if (!chan_active[w_q.ch]) begin
                    w_d.ch = w_q.ch + CNTW'(1);
                end else begin
                    w_d.daddr = cand_addr;
                    w_d.widx  = 2'd0;
                    if (eng_br_arm) begin
                        dis_en = 1'b1;
                        if (eng_br_int) begin
                            w_d.ev_br = 1'b1;
                            w_d.ev_ch = w_q.ch[CHW-1:0];
                        end
                    end
                    w_d.st = desc_ok ? FDW_REQ : FDW_CHECK;
                end
            end
            FDW_REQ: begin
                rd_req_valid = 1'b1;
                if (rd_req_ready) w_d.st = FDW_RSP;
            end
            FDW_RSP: begin
                if (rd_rsp_valid) begin
                    unique case (w_q.widx)
                        2'd0:    w_d.w0 = rd_rsp_data;
                        2'd1:    w_d.w1 = rd_rsp_data;
                        2'd2:    w_d.w2 = rd_rsp_data;
                        default: ld_en  = 1'b1;
                    endcase
                    if (w_q.widx == 2'd3) begin
                        w_d.st = FDW_CHECK;
                    end else begin
                        w_d.widx = w_q.widx + 2'd1;
                        w_d.st   = FDW_REQ;
                    end
                end
            end
            FDW_CHECK: begin
                w_d.ev_ch  = w_q.ch[CHW-1:0];
                w_d.ev_len = 21'h0;
                if (!src_ok) begin
                    w_d.ev_berr = 1'b1;
                    w_d.ch      = w_q.ch + CNTW'(1);
                    w_d.st      = FDW_SCAN;
                end else if (eng_pal) begin
                    w_d.ev_pal = 1'b1;
                    w_d.ev_len = eng_len;
                    w_d.ch     = w_q.ch + CNTW'(1);
                    w_d.st     = FDW_SCAN;
                end else begin
                    w_d.ev_sof = 1'b1;
                    w_d.ev_len = eng_len;
                    w_d.st     = FDW_XFER;
                end
            end
            FDW_XFER: begin
                if (xfer_done) begin
                    w_d.ev_eof = 1'b1;
                    w_d.ev_ch  = w_q.ch[CHW-1:0];
                    w_d.ev_len = 21'h0;
                    w_d.ch     = w_q.ch + CNTW'(1);
                    w_d.st     = FDW_SCAN;
                end
            end
            default: w_d.st = FDW_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= FDW_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign evt_branch  = w_q.ev_br;
    assign evt_sof     = w_q.ev_sof;
    assign evt_eof     = w_q.ev_eof;
    assign evt_palette = w_q.ev_pal;
    assign evt_bus_err = w_q.ev_berr;
    assign evt_ch      = w_q.ev_ch;
    assign evt_len     = w_q.ev_len;
    assign walk_busy   = (w_q.st != FDW_IDLE);
    assign walk_done   = w_q.done;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R1

    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid |-> (({1'b0, rd_req_addr} >= {1'b0, WIN_BASE}) &&
        (({1'b0, rd_req_addr} + 33'd4) <= ({1'b0, WIN_BASE} + {1'b0, WIN_SIZE})))); // R5

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_branch, evt_sof, evt_eof, evt_palette, evt_bus_err})); // R10

    AST_EOF_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_eof |-> $past(xfer_done)); // R8
endmodule

// File: rtl/frame_desc_walker.sv
module frame_desc_walker #(
    parameter int          NCH      = 7,
    parameter logic [31:0] WIN_BASE = 32'h1000_0000,
    parameter logic [31:0] WIN_SIZE = 32'h0000_0400,
    localparam int         CHW      = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int         CNTW     = $clog2(NCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            frame_start,
    input  logic [NCH-1:0]  chan_active,
    input  logic            xfer_done,
    input  logic            cfg_wr_en,
    input  logic            cfg_wr_sel,
    input  logic [CHW-1:0]  cfg_wr_ch,
    input  logic [31:0]     cfg_wr_data,
    output logic            rd_req_valid,
    input  logic            rd_req_ready,
    output logic [31:0]     rd_req_addr,
    input  logic            rd_rsp_valid,
    input  logic [31:0]     rd_rsp_data,
    output logic            evt_branch,
    output logic            evt_sof,
    output logic            evt_eof,
    output logic            evt_palette,
    output logic            evt_bus_err,
    output logic [CHW-1:0]  evt_ch,
    output logic [20:0]     evt_len,
    output logic            walk_busy,
    output logic            walk_done,
    input  logic [CHW-1:0]  peek_ch,
    output logic [31:0]     peek_next,
    output logic [31:0]     peek_src,
    output logic [31:0]     peek_id,
    output logic [31:0]     peek_cmd,
    output logic [31:0]     peek_branch
);
    logic [CHW-1:0] eng_ch, ld_ch, dis_ch;
    logic [31:0]    eng_next, eng_src, eng_br_addr, cand_addr;
    logic [31:0]    ld_next, ld_src, ld_id, ld_cmd;
    logic [20:0]    eng_len;
    logic           eng_pal, eng_br_arm, eng_br_int;
    logic           desc_ok, src_ok, clr_src, ld_en, dis_en;

    fdw_window_chk #(.WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) win_i (
        .desc_addr (cand_addr),
        .src_addr  (eng_src),
        .desc_ok   (desc_ok),
        .src_ok    (src_ok)
    );

    fdw_chan_bank #(.NCH(NCH), .CHW(CHW)) bank_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr_en),
        .wr_sel      (cfg_wr_sel),
        .wr_ch       (cfg_wr_ch),
        .wr_data     (cfg_wr_data),
        .clr_src     (clr_src),
        .ld_en       (ld_en),
        .ld_ch       (ld_ch),
        .ld_next     (ld_next),
        .ld_src      (ld_src),
        .ld_id       (ld_id),
        .ld_cmd      (ld_cmd),
        .dis_en      (dis_en),
        .dis_ch      (dis_ch),
        .eng_ch      (eng_ch),
        .eng_next    (eng_next),
        .eng_src     (eng_src),
        .eng_pal     (eng_pal),
        .eng_len     (eng_len),
        .eng_br_arm  (eng_br_arm),
        .eng_br_int  (eng_br_int),
        .eng_br_addr (eng_br_addr),
        .pk_ch       (peek_ch),
        .pk_next     (peek_next),
        .pk_src      (peek_src),
        .pk_id       (peek_id),
        .pk_cmd      (peek_cmd),
        .pk_br       (peek_branch)
    );

    fdw_walker #(
        .NCH(NCH), .CHW(CHW), .CNTW(CNTW),
        .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
    ) walk_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_start  (frame_start),
        .chan_active  (chan_active),
        .xfer_done    (xfer_done),
        .desc_ok      (desc_ok),
        .src_ok       (src_ok),
        .eng_next     (eng_next),
        .eng_pal      (eng_pal),
        .eng_len      (eng_len),
        .eng_br_arm   (eng_br_arm),
        .eng_br_int   (eng_br_int),
        .eng_br_addr  (eng_br_addr),
        .eng_ch       (eng_ch),
        .cand_addr    (cand_addr),
        .clr_src      (clr_src),
        .ld_en        (ld_en),
        .ld_ch        (ld_ch),
        .ld_next      (ld_next),
        .ld_src       (ld_src),
        .ld_id        (ld_id),
        .ld_cmd       (ld_cmd),
        .dis_en       (dis_en),
        .dis_ch       (dis_ch),
        .rd_req_valid (rd_req_valid),
        .rd_req_ready (rd_req_ready),
        .rd_req_addr  (rd_req_addr),
        .rd_rsp_valid (rd_rsp_valid),
        .rd_rsp_data  (rd_rsp_data),
        .evt_branch   (evt_branch),
        .evt_sof      (evt_sof),
        .evt_eof      (evt_eof),
        .evt_palette  (evt_palette),
        .evt_bus_err  (evt_bus_err),
        .evt_ch       (evt_ch),
        .evt_len      (evt_len),
        .walk_busy    (walk_busy),
        .walk_done    (walk_done)
    );
endmodule

// File: tb/frame_desc_walker_tb_top.sv
module frame_desc_walker_tb_top;
    localparam int          NCH  = 7;
    localparam logic [31:0] BASE = 32'h1000_0000;
    localparam logic [31:0] SIZE = 32'h0000_0400;

    // event log entry: {code[3:0], channel[3:0], length[23:0]}
    // codes: 1 branch, 2 sof, 3 eof, 4 palette, 5 bus error
    localparam int NEXP = 16;
    localparam logic [31:0] EXP [NEXP] = '{
        32'h2000_0040, 32'h3000_0000, 32'h1200_0000, 32'h4200_0020,
        32'h5300_0000, 32'h5400_0000, 32'h5500_0000, 32'h2600_0080,
        32'h3600_0000,
        32'h2000_0010, 32'h3000_0000, 32'h2200_0100, 32'h3200_0000,
        32'h5300_0000, 32'h2400_0004, 32'h3400_0000
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0, frame_start = 1'b0, xfer_done = 1'b0;
    logic [NCH-1:0] chan_active = '0;
    logic cfg_wr_en = 1'b0, cfg_wr_sel = 1'b0;
    logic [2:0] cfg_wr_ch = '0, peek_ch = '0, evt_ch;
    logic [31:0] cfg_wr_data = '0;
    logic rd_req_valid, rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
    logic [31:0] rd_req_addr, rd_rsp_data = '0;
    logic evt_branch, evt_sof, evt_eof, evt_palette, evt_bus_err, walk_busy, walk_done;
    logic [20:0] evt_len;
    logic [31:0] peek_next, peek_src, peek_id, peek_cmd, peek_branch;

    frame_desc_walker #(.NCH(NCH), .WIN_BASE(BASE), .WIN_SIZE(SIZE)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .chan_active(chan_active),
        .xfer_done(xfer_done), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_ch(cfg_wr_ch), .cfg_wr_data(cfg_wr_data), .rd_req_valid(rd_req_valid),
        .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
        .rd_rsp_data(rd_rsp_data), .evt_branch(evt_branch), .evt_sof(evt_sof),
        .evt_eof(evt_eof), .evt_palette(evt_palette), .evt_bus_err(evt_bus_err),
        .evt_ch(evt_ch), .evt_len(evt_len), .walk_busy(walk_busy), .walk_done(walk_done),
        .peek_ch(peek_ch), .peek_next(peek_next), .peek_src(peek_src), .peek_id(peek_id),
        .peek_cmd(peek_cmd), .peek_branch(peek_branch)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0] mem [256];
    logic [31:0] lg [32];
    int lg_n = 0, done_cnt = 0, bad_addr = 0, stall = 0, xcnt = 0;
    logic pend = 1'b0;
    logic [31:0] pend_addr = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] dptr(input int slot);
        return BASE + 32'(slot * 16);
    endfunction

    task automatic put_desc(input int slot, input logic [31:0] nx, input logic [31:0] sa,
                            input logic [31:0] id, input logic [31:0] cm);
        mem[slot*4]   = nx;
        mem[slot*4+1] = sa;
        mem[slot*4+2] = id;
        mem[slot*4+3] = cm;
    endtask

    task automatic cfg_write(input logic sel, input int ch, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_ch = 3'(ch); cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic peek(input int ch);
        peek_ch = 3'(ch);
        #1;
    endtask

    // memory model: accepts a request at a negedge, answers one cycle after the handshake
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_rsp_valid) begin
                rd_rsp_valid = 1'b0;
                pend = 1'b0;
            end
            if (rd_req_ready) begin
                rd_req_ready = 1'b0;
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem[8'((pend_addr - BASE) >> 2)];
            end else if (!pend && rd_req_valid) begin
                stall++;
                if ((stall % 3) != 1) begin
                    if (rd_req_addr < BASE || rd_req_addr >= BASE + SIZE) bad_addr++;
                    rd_req_ready = 1'b1;
                    pend = 1'b1;
                    pend_addr = rd_req_addr;
                end
            end
        end
    end

    // transfer model and event logger
    always @(negedge clk) begin
        xfer_done = 1'b0;
        if (xcnt > 0) begin
            xcnt--;
            if (xcnt == 0) xfer_done = 1'b1;
        end
        if (evt_sof) xcnt = 3;
        if (lg_n < 32) begin
            if (evt_branch)  begin lg[lg_n] = {4'h1, 1'b0, evt_ch, 24'h0}; lg_n++; end
            if (evt_sof)     begin lg[lg_n] = {4'h2, 1'b0, evt_ch, 3'b0, evt_len}; lg_n++; end
            if (evt_eof)     begin lg[lg_n] = {4'h3, 1'b0, evt_ch, 24'h0}; lg_n++; end
            if (evt_palette) begin lg[lg_n] = {4'h4, 1'b0, evt_ch, 3'b0, evt_len}; lg_n++; end
            if (evt_bus_err) begin lg[lg_n] = {4'h5, 1'b0, evt_ch, 24'h0}; lg_n++; end
        end
        if (walk_done) done_cnt++;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        put_desc(1,  dptr(2), BASE + 32'h200, 32'hA0, 32'h0000_0043);
        put_desc(3,  dptr(5), BASE + 32'h210, 32'hA3, 32'h0400_0021);
        put_desc(4,  dptr(1), BASE + 32'h300, 32'hA4, 32'h0000_0044);
        put_desc(5,  dptr(1), BASE + 32'h230, 32'hA5, 32'h0020_0100);
        put_desc(6,  32'h0,   32'h0,          32'hA6, 32'h0000_0040);
        put_desc(7,  32'h0,   BASE + 32'h500, 32'hA7, 32'h0000_0040);
        put_desc(8,  32'h0,   BASE + 32'h240, 32'hA8, 32'h0000_0007);
        put_desc(9,  dptr(2), BASE + 32'h220, 32'hA9, 32'h0000_0012);
        put_desc(63, dptr(1), BASE + 32'h400, 32'hAF, 32'h0000_0080);

        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 busy", {31'b0, walk_busy}, 32'h0);
        chk("R11 req", {31'b0, rd_req_valid}, 32'h0);
        for (int c = 0; c < NCH; c++) begin
            peek(c);
            chk("R11 regs", peek_next | peek_src | peek_id | peek_cmd | peek_branch, 32'h0);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // frame 1 setup; R9: masking of both write kinds
        cfg_write(1'b0, 0, dptr(1));
        cfg_write(1'b0, 2, dptr(4));
        cfg_write(1'b1, 2, dptr(3) | 32'hF);
        cfg_write(1'b0, 3, 32'h2000_0000);
        cfg_write(1'b0, 4, dptr(6) | 32'hF);
        cfg_write(1'b0, 5, dptr(7));
        cfg_write(1'b0, 6, dptr(63));
        peek(2); chk("R9 branch mask", peek_branch, dptr(3) | 32'h3);
        peek(4); chk("R9 pointer align", peek_next, dptr(6));

        chan_active = 7'b111_1101;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        while (!walk_done) @(negedge clk);
        @(negedge clk);

        peek(0); chk("R1 next", peek_next, dptr(2));
        chk("R1 src", peek_src, BASE + 32'h200);
        chk("R1 id", peek_id, 32'hA0);
        chk("R1 cmd", peek_cmd, 32'h43);
        peek(1); chk("R2 skipped src", peek_src, 32'h0);
        peek(2); chk("R4 disarmed", peek_branch, dptr(3) | 32'h2);
        chk("R4 next from branch", peek_next, dptr(5));
        peek(3); chk("R5 no fetch src", peek_src, 32'h0);
        chk("R5 no fetch next", peek_next, 32'h2000_0000);
        peek(6); chk("R6 top bound src", peek_src, BASE + 32'h400);

        // frame 2: branch without interrupt, linked pointer, bad window edge
        cfg_write(1'b1, 0, dptr(9) | 32'h1);
        cfg_write(1'b0, 3, BASE + SIZE);
        cfg_write(1'b0, 4, dptr(8) | 32'h5);
        chan_active = 7'b001_1101;
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
        repeat (4) @(negedge clk);
        frame_start = 1'b1;   // R2: ignored while busy
        @(negedge clk); frame_start = 1'b0;
        while (!walk_done) @(negedge clk);
        repeat (20) @(negedge clk);

        chk("R2 done count", 32'(done_cnt), 32'd2);
        chk("R2 idle", {31'b0, walk_busy}, 32'h0);
        peek(6); chk("R3 cleared src", peek_src, 32'h0);
        peek(0); chk("R4 disarm no int", peek_branch, dptr(9));
        chk("R4 branch src", peek_src, BASE + 32'h220);
        peek(4); chk("R8 src", peek_src, BASE + 32'h240);
        chk("R5 reads in window", 32'(bad_addr), 32'h0);

        // event stream table (R4 R6 R7 R8 R10)
        chk("R10 event count", 32'(lg_n), 32'(NEXP));
        for (int i = 0; i < NEXP; i++) begin
            chk("R6 R7 R8 R10 event", (i < lg_n) ? lg[i] : 32'hFFFF_FFFF, EXP[i]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule